// File: doc/BRIEF.md
# Pixel Hit Time-of-Arrival and Over-Threshold Digitizer

This block is the digital back end of one detector pixel. It takes the discriminator output of the analog front end and turns each hit into a timing record. A fast clock, sixteen times the sync clock, is counted from the hit's rising edge up to the next sync edge. The result is a fine stamp. At that same sync edge a coarse stamp is captured from the global time-stamp bus. After that the block counts the sync edges at which the discriminator is still high, which gives the time over threshold. The finished record is held with a valid flag until the column readout acknowledges it.

All logic runs on the fast clock. The sync clock and the hit are inputs whose rising edges are detected in that clock domain.

Three acquisition modes are selected by `mode_i`:
- Arrival plus over-threshold time (`00`, also `11`).
- Arrival only (`01`).
- Event counting (`10`). This mode keeps a running hit count and an integrated over-threshold total in place of per-hit records. An acknowledge clears both.

Top module: `pix_hit_digitizer`

## Requirements
- R1: After reset `valid_o` is 0 and `data_o[27:0]` is all zeros.
- R2: The fine field `data_o[3:0]` is the number of fast-clock edges from the edge that first sees the hit high up to, but not including, the next edge that sees a sync-clock rise. It is 0 when both coincide.
- R3: The coarse field `data_o[27:14]` holds `ts_i` as sampled at that stopping sync edge. The arrival time in fast ticks therefore equals coarse×16 − fine, modulo 2^18.
- R4: In modes `00` and `11`, the over-threshold field `data_o[13:4]` counts the sync edges, from the stopping edge onward, at which `hit_i` is high. The record becomes valid after the first sync edge at which `hit_i` is low.
- R5: The over-threshold field saturates at 1023 and does not wrap.
- R6: In mode `01` the record becomes valid at the stopping sync edge, and its over-threshold field is 0.
- R7: While `valid_o` is 1, new hits are ignored and the record fields stay unchanged.
- R8: When `ack_i` is high while `valid_o` is 1, `valid_o` is 0 from the next cycle.
- R9: In mode `10`, `valid_o` stays 0. `data_o[13:4]` counts hit rising edges, and `data_o[27:14]` counts the sync edges at which `hit_i` is high.
- R10: In mode `10` the hit count saturates at 1023, and `ack_i` clears both counters to 0.
- R11: `data_o[43:28]` always equals `pix_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast clock, 16× the sync clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_clk_i | input | 1 | Sync clock, its rising edge sampled in the fast domain |
| hit_i | input | 1 | Discriminator output |
| ts_i | input | 14 | Global coarse time-stamp bus |
| mode_i | input | 2 | Acquisition mode: 00 arrival+ToT, 01 arrival only, 10 count, 11 as 00 |
| ack_i | input | 1 | Readout acknowledge / counter clear in count mode |
| pix_addr_i | input | 16 | Pixel coordinate inserted in the record |
| valid_o | output | 1 | Record waiting for readout |
| data_o | output | 44 | {addr[15:0], coarse/integral[13:0], tot/count[9:0], fine[3:0]} |

## Verification
Hits are started at every kind of phase relative to the sync clock:
- On the sync edge itself, which separates a zero fine value from a full count.
- One tick after the edge and one tick before it, which expose off-by-one errors in the fine counter and in the choice of coarse stamp.
- Across a wrap of the time-stamp bus, which checks the arrival reconstruction modulo 2^18.

Hit lengths run from one tick, which ends before any sync edge, through several sync periods, to a length beyond the over-threshold range, which separates saturation from wrapping. Count mode is driven both with overlapping sync edges, to check the integral, and with a long burst of short hits, to check the saturating hit count.

// File: rtl/pix_tdc_pkg.sv
package pix_tdc_pkg;
  typedef enum logic [1:0] {
    MODE_TOA_TOT = 2'b00,
    MODE_TOA     = 2'b01,
    MODE_COUNT   = 2'b10,
    MODE_ALT     = 2'b11
  } acq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_FINE = 2'b01,
    ST_TOT  = 2'b10
  } meas_state_e;
endpackage

// File: rtl/pix_edge_det.sv
module pix_edge_det #(
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic q;

  // reset high so a level present at reset release is not taken as an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST_VAL;
    else         q <= d_i;
  end

  assign rise_o = d_i & ~q;
endmodule

// File: rtl/pix_sat_counter.sv
module pix_sat_counter #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;

  // clear with a coincident increment restarts at one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= inc_i ? ONE : '0;
    else if (inc_i && (cnt_q != MAX)) cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pix_fine_tdc.sv
module pix_fine_tdc #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         stop_i,
  output logic [W-1:0] fine_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic         run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= stop_i ? '0 : ONE;
      run_q <= ~stop_i;
    end else if (run_q) begin
      if (stop_i) run_q <= 1'b0;
      else        cnt_q <= cnt_q + ONE;
    end
  end

  assign fine_o = cnt_q;
endmodule

// File: rtl/pix_hit_digitizer.sv
module pix_hit_digitizer
  import pix_tdc_pkg::*;
#(
  parameter int FINE_W   = 4,
  parameter int COARSE_W = 14,
  parameter int TOT_W    = 10,
  parameter int ADDR_W   = 16
) (
  input  logic                                      clk_fast_i,
  input  logic                                      rst_ni,
  input  logic                                      sync_clk_i,
  input  logic                                      hit_i,
  input  logic [COARSE_W-1:0]                       ts_i,
  input  logic [1:0]                                mode_i,
  input  logic                                      ack_i,
  input  logic [ADDR_W-1:0]                         pix_addr_i,
  output logic                                      valid_o,
  output logic [ADDR_W+COARSE_W+TOT_W+FINE_W-1:0]   data_o
);
  localparam int REC_W = ADDR_W + COARSE_W + TOT_W + FINE_W;

  acq_mode_e   mode;
  meas_state_e state_q, state_d;
  logic        count_mode, toa_only;
  logic        sync_rise, hit_rise;
  logic        start, done, coarse_ld, tot_clr, tot_inc;
  logic        valid_q;
  logic [COARSE_W-1:0] coarse_q;
  logic [FINE_W-1:0]   fine;
  logic [TOT_W-1:0]    tot;
  logic [TOT_W-1:0]    evt_cnt;
  logic [COARSE_W-1:0] itot_cnt;

  assign mode       = acq_mode_e'(mode_i);
  assign count_mode = (mode == MODE_COUNT);
  assign toa_only   = (mode == MODE_TOA);

  pix_edge_det #(.RST_VAL(1'b1)) u_sync_edge (
    .clk_i (clk_fast_i), .rst_ni(rst_ni), .d_i(sync_clk_i), .rise_o(sync_rise)
  );

  pix_edge_det #(.RST_VAL(1'b1)) u_hit_edge (
    .clk_i (clk_fast_i), .rst_ni(rst_ni), .d_i(hit_i), .rise_o(hit_rise)
  );

  // hold-off: no new measurement while a record waits
  assign start = (state_q == ST_IDLE) && hit_rise && !valid_q && !count_mode;

  pix_fine_tdc #(.W(FINE_W)) u_fine (
    .clk_i (clk_fast_i), .rst_ni(rst_ni), .start_i(start), .stop_i(sync_rise), .fine_o(fine)
  );

  always_comb begin
    state_d   = state_q;
    done      = 1'b0;
    coarse_ld = 1'b0;
    tot_clr   = 1'b0;
    tot_inc   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (sync_rise) begin
            coarse_ld = 1'b1;
            tot_clr   = 1'b1;
            tot_inc   = hit_i;
            if (toa_only) done = 1'b1;
            else          state_d = ST_TOT;
          end else begin
            state_d = ST_FINE;
          end
        end
      end
      ST_FINE: begin
        if (sync_rise) begin
          coarse_ld = 1'b1;
          tot_clr   = 1'b1;
          tot_inc   = hit_i;
          if (toa_only || !hit_i) begin
            done    = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_TOT;
          end
        end
      end
      ST_TOT: begin
        if (sync_rise) begin
          if (hit_i) begin
            tot_inc = 1'b1;
          end else begin
            done    = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_fast_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      valid_q  <= 1'b0;
      coarse_q <= '0;
    end else begin
      state_q <= state_d;
      if (coarse_ld) coarse_q <= ts_i;
      if (valid_q && ack_i) valid_q <= 1'b0;
      else if (done)        valid_q <= 1'b1;
    end
  end

  pix_sat_counter #(.W(TOT_W)) u_tot (
    .clk_i (clk_fast_i), .rst_ni(rst_ni), .clr_i(tot_clr), .inc_i(tot_inc), .cnt_o(tot)
  );

  pix_sat_counter #(.W(TOT_W)) u_evt (
    .clk_i (clk_fast_i), .rst_ni(rst_ni),
    .clr_i (count_mode && ack_i), .inc_i(count_mode && hit_rise), .cnt_o(evt_cnt)
  );

  pix_sat_counter #(.W(COARSE_W)) u_itot (
    .clk_i (clk_fast_i), .rst_ni(rst_ni),
    .clr_i (count_mode && ack_i), .inc_i(count_mode && sync_rise && hit_i), .cnt_o(itot_cnt)
  );

  logic [REC_W-1:0] meas_rec, cnt_rec;
  assign meas_rec = {pix_addr_i, coarse_q, (toa_only ? {TOT_W{1'b0}} : tot), fine};
  assign cnt_rec  = {pix_addr_i, itot_cnt, evt_cnt, {FINE_W{1'b0}}};

  assign valid_o = valid_q;
  assign data_o  = count_mode ? cnt_rec : meas_rec;
endmodule

// File: rtl/pix_hit_digitizer_chk.sv
module pix_hit_digitizer_chk #(
  parameter int FINE_W = 4,
  parameter int TOT_W  = 10,
  parameter int REC_W  = 44
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             ack_i,
  input logic             valid_o,
  input logic [REC_W-1:0] data_o,
  input logic [1:0]       state_q,
  input logic [TOT_W-1:0] tot_cnt
);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ack_i) |=> valid_o)
    else $error("record dropped without acknowledge");

  p_ack_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ack_i) |=> !valid_o)
    else $error("acknowledge did not clear valid");

  p_toa_zero_tot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_i == 2'b01) |-> (data_o[FINE_W+TOT_W-1:FINE_W] == '0))
    else $error("arrival-only record carries over-threshold time");

  p_count_no_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && !valid_o) |=> !valid_o)
    else $error("record produced in count mode");

  p_tot_sat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == pix_tdc_pkg::ST_TOT && tot_cnt == {TOT_W{1'b1}}) |=> (tot_cnt == {TOT_W{1'b1}}))
    else $error("over-threshold counter wrapped");
endmodule

bind pix_hit_digitizer pix_hit_digitizer_chk #(
  .FINE_W(FINE_W), .TOT_W(TOT_W), .REC_W(REC_W)
) u_chk (
  .clk_i  (clk_fast_i),
  .rst_ni (rst_ni),
  .mode_i (mode_i),
  .ack_i  (ack_i),
  .valid_o(valid_o),
  .data_o (data_o),
  .state_q(state_q),
  .tot_cnt(tot)
);

// File: tb/pix_hit_digitizer_test.sv
module pix_hit_digitizer_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hit = 1'b0;
  logic        ack = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] addr = 16'h1234;
  logic [3:0]  phase = 4'd0;
  logic [13:0] ts = 14'd16370;
  logic        sync_clk;
  logic        valid;
  logic [43:0] data;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    phase <= phase + 4'd1;
    if (phase == 4'd15) ts <= ts + 14'd1;
  end
  assign sync_clk = (phase < 4'd8);

  pix_hit_digitizer uut (
    .clk_fast_i(clk), .rst_ni(rst_ni), .sync_clk_i(sync_clk), .hit_i(hit),
    .ts_i(ts), .mode_i(mode), .ack_i(ack), .pix_addr_i(addr),
    .valid_o(valid), .data_o(data)
  );

  localparam int NV = 8;
  localparam int V_MODE[NV] = '{0, 0, 0, 0, 1, 1, 3, 0};
  localparam int V_PH[NV]   = '{3, 0, 15, 1, 7, 0, 8, 12};
  localparam int V_LEN[NV]  = '{40, 16, 5, 1, 30, 3, 100, 200};

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sync_hits(input int p, input int len);
    int off = (16 - p) % 16;
    return (off < len) ? (len - off + 15) / 16 : 0;
  endfunction

  task automatic drive_hit(input int p, input int len, output logic [17:0] t0);
    @(negedge clk); #1;
    while (int'(phase) != p) begin @(negedge clk); #1; end
    t0  = {ts, phase};
    hit = 1'b1;
    repeat (len) begin @(negedge clk); #1; end
    hit = 1'b0;
  endtask

  task automatic wait_valid(input int limit);
    int n = 0;
    while (!valid && n < limit) begin @(negedge clk); #1; n++; end
  endtask

  task automatic do_ack;
    @(negedge clk); #1 ack = 1'b1;
    @(negedge clk); #1 ack = 1'b0;
  endtask

  task automatic run_record(input int m, input int p, input int len, input logic [15:0] a);
    logic [17:0] t0, ctick;
    int off, tot_e;
    mode = m[1:0];
    addr = a;
    drive_hit(p, len, t0);
    wait_valid(64);
    off   = (16 - p) % 16;
    ctick = t0 + 18'(off);
    tot_e = (m == 1) ? 0 : sync_hits(p, len);
    if (tot_e > 1023) tot_e = 1023;
    chk(valid, "R4", "valid after hit", valid, 1);
    chk(data[3:0] == 4'(off), "R2", "fine", data[3:0], off);
    chk(data[27:14] == ctick[17:4], "R3", "coarse", data[27:14], ctick[17:4]);
    chk(({data[27:14], 4'b0} - 18'(data[3:0])) == t0, "R3", "arrival",
        {data[27:14], 4'b0} - 18'(data[3:0]), t0);
    if (m == 1) chk(data[13:4] == 0, "R6", "tot in arrival mode", data[13:4], 0);
    else if (tot_e == 1023) chk(data[13:4] == 10'd1023, "R5", "tot saturated", data[13:4], 1023);
    else chk(data[13:4] == 10'(tot_e), "R4", "tot", data[13:4], tot_e);
    chk(data[43:28] == a, "R11", "address", data[43:28], a);
    do_ack();
    chk(!valid, "R8", "valid after ack", valid, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [17:0] t_dummy;
    logic [43:0] saved;
    int itot_e;
    repeat (5) @(negedge clk);
    #1;
    chk(!valid, "R1", "valid in reset", valid, 0);
    chk(data[27:0] == 28'd0, "R1", "fields in reset", data[27:0], 0);
    @(negedge clk); rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!valid && data[27:0] == 28'd0, "R1", "after release", data[27:0], 0);

    for (int i = 0; i < NV; i++)
      run_record(V_MODE[i], V_PH[i], V_LEN[i], 16'hA000 + 16'(i));

    // over-threshold saturation (R5)
    run_record(0, 5, 16500, 16'h5A5A);

    // hold-off while a record waits (R7)
    mode = 2'b00;
    drive_hit(4, 20, t_dummy);
    wait_valid(64);
    saved = data;
    drive_hit(9, 30, t_dummy);
    repeat (60) @(negedge clk);
    #1;
    chk(valid, "R7", "valid held", valid, 1);
    chk(data == saved, "R7", "record held", data[27:0], saved[27:0]);
    do_ack();
    repeat (40) @(negedge clk);
    #1;
    chk(!valid, "R7", "ignored hit left no record", valid, 0);

    // count mode (R9, R10)
    mode = 2'b10;
    do_ack();
    drive_hit(3, 40, t_dummy);
    drive_hit(0, 16, t_dummy);
    drive_hit(10, 3, t_dummy);
    repeat (4) @(negedge clk);
    #1;
    itot_e = sync_hits(3, 40) + sync_hits(0, 16) + sync_hits(10, 3);
    chk(data[13:4] == 10'd3, "R9", "event count", data[13:4], 3);
    chk(data[27:14] == 14'(itot_e), "R9", "integral", data[27:14], itot_e);
    chk(!valid, "R9", "no valid in count mode", valid, 0);
    do_ack();
    chk(data[27:4] == 24'd0, "R10", "ack clears counters", data[27:4], 0);
    for (int i = 0; i < 1030; i++) begin
      @(negedge clk); #1 hit = 1'b1;
      @(negedge clk); #1 hit = 1'b0;
    end
    repeat (2) @(negedge clk);
    #1;
    chk(data[13:4] == 10'd1023, "R10", "event count saturates", data[13:4], 1023);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule